// File: doc/BRIEF.md
# Bounded Service Latency Monitor

This block is a synthesizable checker placed beside an arbiter that shares one resource among three clients. It watches for client A being starved: A is requesting, A has not been acknowledged, and neither of the other two clients is competing for the resource. While nothing competes with A, the arbiter has no excuse to keep A waiting. So the monitor counts consecutive cycles of this kind and raises an error once the count passes a configurable bound.

The count is qualified by the absence of competition. Any cycle in which the condition breaks sends the count back to zero. Such a cycle is one where A is acknowledged, A stops requesting, or another client requests. The error flag is absorbing: once it is set, only reset clears it. The current wait count is brought out for debug.

Each client state is a 2-bit code: 2'b00 means not requesting, 2'b01 means requesting, and 2'b10 means holding the resource. The code 2'b11 is treated as not requesting.

Top module: `latency_watch`

## Requirements
- R1: A low `rst_n` sampled at a rising clock edge sets `wait_cnt_o` to 0 and `err_o` to 0 after that edge.
- R2: A cycle counts as unserved only when `state_a` is 2'b01, `ack_a` is 0, and neither `state_b` nor `state_c` is 2'b01.
- R3: Each rising edge that samples an unserved cycle raises `wait_cnt_o` by one, until the count reaches BOUND+1.
- R4: Any rising edge that samples a cycle that is not unserved sets `wait_cnt_o` to 0. This covers an acknowledge, A leaving its request state, and a rival request.
- R5: `err_o` rises at the edge that samples the (BOUND+1)-th consecutive unserved cycle. BOUND or fewer consecutive unserved cycles leave it low.
- R6: Once `err_o` is 1, it stays 1 until reset, whatever the inputs do.
- R7: `wait_cnt_o` never exceeds BOUND+1. It holds at BOUND+1 while unserved cycles continue.
- R8: A rival in state 2'b10 or 2'b11 does not compete, so it does not stop the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| state_a | input | 2 | Client A state code |
| state_b | input | 2 | Client B state code |
| state_c | input | 2 | Client C state code |
| ack_a | input | 1 | Acknowledge to client A |
| err_o | output | 1 | Sticky starvation error |
| wait_cnt_o | output | $clog2(BOUND+2) | Consecutive unserved cycle count |

## Verification
Both outputs are registered. Their values are therefore due one rising edge after the input cycle that causes them, with no combinational path to the outputs. The bench drives inputs at the falling edge and steps a model of count and error at the next rising edge. It compares 1 ns after that edge, so each comparison sees exactly the cycle just sampled. A sweep covers all 128 input combinations from reset. Run-length tests cover 0 to 6 unserved cycles, an acknowledge exactly at the bound, and rival requests that break the count.

// File: rtl/latency_watch_pkg.sv
// Shared client state codes for the service latency monitor.
package latency_watch_pkg;
    typedef enum logic [1:0] {
        CL_IDLE = 2'b00,
        CL_REQ  = 2'b01,
        CL_HOLD = 2'b10,
        CL_RSVD = 2'b11
    } client_st_e;
endpackage

// File: rtl/lw_starve_detect.sv
// Combinational detector for the unserved condition.
// Assumes: the rival states are packed two bits per client, and only the
// request code counts as competition.
module lw_starve_detect #(
    parameter int NUM_RIVALS = 2
) (
    input  logic [1:0]              own_st,
    input  logic                    own_ack,
    input  logic [2*NUM_RIVALS-1:0] rival_st,
    output logic                    unserved
);
    import latency_watch_pkg::*;

    logic [NUM_RIVALS-1:0] rival_req;

    // One competition flag per rival client.
    for (genvar i = 0; i < NUM_RIVALS; i++) begin : g_rival
        assign rival_req[i] = (rival_st[2*i +: 2] == CL_REQ);
    end

    // A waits, is not acknowledged, and nobody competes.
    always_comb begin
        unserved = (own_st == CL_REQ) && !own_ack && (rival_req == '0);
    end
endmodule

// File: rtl/lw_wait_counter.sv
// Saturating count of consecutive unserved cycles.
// Assumes: a synchronous active-low reset. The count saturates at BOUND+1.
// at_limit flags a hit sampled while the count already stands at BOUND or above.
module lw_wait_counter #(
    parameter int BOUND = 3,
    parameter int CW    = $clog2(BOUND + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    output logic [CW-1:0] cnt,
    output logic          at_limit
);
    localparam logic [CW-1:0] SAT = CW'(BOUND + 1);
    localparam logic [CW-1:0] LIM = CW'(BOUND);

    // Count consecutive hits and clear on any miss.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!hit)       cnt <= '0;
        else if (cnt != SAT) cnt <= cnt + 1'b1;
    end

    // This hit would take the wait past the bound.
    always_comb begin
        at_limit = hit && (cnt >= LIM);
    end
endmodule

// File: rtl/lw_sticky_flag.sv
// Absorbing error flag.
// Assumes: a synchronous active-low reset is the only way to clear it.
module lw_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    output logic flag
);
    // Latch the violation and hold it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= flag | set;
    end
endmodule

// File: rtl/latency_watch.sv
// Top of the bounded service latency monitor.
// Assumes: client states use the latency_watch_pkg codes, and B and C are
// the competing clients.
module latency_watch #(
    parameter int BOUND = 3,
    parameter int CW    = $clog2(BOUND + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    state_a,
    input  logic [1:0]    state_b,
    input  logic [1:0]    state_c,
    input  logic          ack_a,
    output logic          err_o,
    output logic [CW-1:0] wait_cnt_o
);
    localparam int NUM_RIVALS = 2;

    logic unserved;
    logic at_limit;

    lw_starve_detect #(.NUM_RIVALS(NUM_RIVALS)) u_detect (
        .own_st   (state_a),
        .own_ack  (ack_a),
        .rival_st ({state_c, state_b}),
        .unserved (unserved)
    );

    lw_wait_counter #(.BOUND(BOUND), .CW(CW)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (unserved),
        .cnt      (wait_cnt_o),
        .at_limit (at_limit)
    );

    lw_sticky_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (at_limit),
        .flag  (err_o)
    );
endmodule

// File: rtl/latency_watch_checker.sv
// Property checker for latency_watch, attached through bind.
module latency_watch_checker #(
    parameter int BOUND = 3,
    parameter int CW    = $clog2(BOUND + 2)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    state_a,
    input logic [1:0]    state_b,
    input logic [1:0]    state_c,
    input logic          ack_a,
    input logic          err_o,
    input logic [CW-1:0] wait_cnt_o
);
    logic starve;
    assign starve = (state_a == 2'b01) && !ack_a
                    && (state_b != 2'b01) && (state_c != 2'b01);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (wait_cnt_o == '0) && !err_o);

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (starve && wait_cnt_o <= CW'(BOUND)) |=> wait_cnt_o == $past(wait_cnt_o) + 1'b1);

    a_r4_break_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !starve |=> wait_cnt_o == '0);

    a_r5_err_at_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> wait_cnt_o == CW'(BOUND + 1));

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt_o <= CW'(BOUND + 1));
endmodule

bind latency_watch latency_watch_checker #(.BOUND(BOUND), .CW(CW)) u_checker (.*);

// File: tb/latency_watch_bench.sv
`timescale 1ns/1ps
module latency_watch_bench;
    localparam int BOUND = 3;
    localparam int CW    = $clog2(BOUND + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    state_a = 2'b00, state_b = 2'b00, state_c = 2'b00;
    logic          ack_a = 1'b0;
    logic          err_o;
    logic [CW-1:0] wait_cnt_o;

    int checks = 0;
    int fails  = 0;
    int exp_cnt = 0;
    bit exp_err = 1'b0;

    always #2.5 clk = ~clk;

    latency_watch #(.BOUND(BOUND)) u_latency_watch (
        .clk(clk), .rst_n(rst_n), .state_a(state_a), .state_b(state_b),
        .state_c(state_c), .ack_a(ack_a), .err_o(err_o), .wait_cnt_o(wait_cnt_o)
    );

    task automatic check(input string tag);
        checks++;
        if (int'(wait_cnt_o) != exp_cnt) begin
            fails++;
            $display("FAIL %s count: got %0d expected %0d", tag, wait_cnt_o, exp_cnt);
        end
        checks++;
        if (err_o != exp_err) begin
            fails++;
            $display("FAIL %s error: got %0b expected %0b", tag, err_o, exp_err);
        end
    endtask

    // Drive one cycle, step the model at the edge, compare 1 ns later.
    task automatic step(input logic [1:0] a, input logic [1:0] b,
                        input logic [1:0] c, input logic k, input string tag);
        bit u;
        @(negedge clk);
        state_a = a; state_b = b; state_c = c; ack_a = k; rst_n = 1'b1;
        u = (a == 2'b01) && !k && (b != 2'b01) && (c != 2'b01);
        @(posedge clk);
        if (u && exp_cnt >= BOUND) exp_err = 1'b1;
        exp_cnt = u ? ((exp_cnt < BOUND + 1) ? exp_cnt + 1 : exp_cnt) : 0;
        #1 check(tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0; state_a = 2'b01; ack_a = 1'b0; state_b = 2'b00; state_c = 2'b00;
        @(posedge clk);
        exp_cnt = 0; exp_err = 1'b0;
        #1 check(tag);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset("R1 initial reset");
        // R2 R8: every input combination from a cleared state
        for (int v = 0; v < 128; v++) begin
            do_reset("R1 sweep reset");
            step(v[1:0], v[3:2], v[5:4], v[6], "R2 R8 sweep");
        end
        // R3 R5 R7 R4 R6: run lengths 0..6 then an acknowledge break
        for (int n = 0; n <= 6; n++) begin
            do_reset("R1 run reset");
            for (int i = 0; i < n; i++) step(2'b01, 2'b10, 2'b11, 1'b0, "R3 R5 R7 run");
            step(2'b01, 2'b00, 2'b00, 1'b1, "R4 R6 ack break");
            step(2'b00, 2'b00, 2'b00, 1'b0, "R6 idle after break");
        end
        // R5: acknowledge exactly at the bound, no error
        do_reset("R1 reset");
        for (int i = 0; i < BOUND; i++) step(2'b01, 2'b00, 2'b00, 1'b0, "R5 at bound");
        step(2'b10, 2'b00, 2'b00, 1'b1, "R5 ack at bound");
        // R4: rivals break the count before the bound
        for (int i = 0; i < BOUND; i++) step(2'b01, 2'b00, 2'b00, 1'b0, "R3 wait");
        step(2'b01, 2'b01, 2'b00, 1'b0, "R4 rival B");
        for (int i = 0; i < BOUND; i++) step(2'b01, 2'b00, 2'b00, 1'b0, "R3 wait");
        step(2'b01, 2'b00, 2'b01, 1'b0, "R4 rival C");
        // R5 R6: one cycle too long, then the error must survive activity
        for (int i = 0; i <= BOUND; i++) step(2'b01, 2'b00, 2'b00, 1'b0, "R5 overrun");
        for (int i = 0; i < 4; i++) step(2'b00, 2'b01, 2'b01, 1'b1, "R6 sticky");
        do_reset("R1 clears error");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule